// File: doc/BRIEF.md
# Ethernet PHY Management Register Front-End

This block is the host-facing side of an Ethernet management unit. Software reaches a small bus-mapped register set. The block carries out PHY management transactions against a PHY control and status model held on chip. The serial management wires are not driven. A management read is requested through a command register. A management write is requested by writing the data register. The result of a read lands in a read-only result register, where the host can fetch it on the next cycle.

A bank of general-purpose registers sits beside the management registers. Each register in the bank has its own access type, chosen by parameter: read/write, write-only, write-one-to-clear or read-only. The write-one-to-clear registers collect hardware events from a set input. The PHY status model follows a link-down input. The host therefore sees link loss through an ordinary management read of PHY register 1.

Top module: `mii_mgmt_regs`

## Requirements
- R1: The address register is at bus offset 1. Bits 4:0 select the PHY register used by both read and write transactions. Bits 12:8 hold a PHY address that is stored and read back but changes no behaviour. The full 32-bit value written is read back.
- R2: The command register is at offset 1-less, offset 0. A read transaction starts only when a bus write to offset 0 has bit 0 set while the stored bit 0 is 0. Every write to offset 0 stores the whole value, including writes that start nothing.
- R3: A read transaction loads the result register at offset 3 on the clock edge that takes the triggering write. The value depends on the selected PHY register: 0 gives the PHY control value, 1 gives the PHY status value, 10 gives 0x1800, and any other number gives 0. Offset 3 ignores bus writes.
- R4: A bus write to offset 2 stores bits 15:0 of the data, and bits 31:16 read back as 0. On the same edge it performs a write transaction to the selected PHY register.
- R5: A write transaction to PHY register 0 stores the data with bits 15 and 8 cleared. A write transaction to any other PHY register changes no PHY state.
- R6: The general bank sits at offsets 8 to 15, and entry i takes access code GEN_ACC[3i+2:3i]. Code 0 (read/write) and code 1 (write-only) store the full written value. The default codes are 0,0,1,1,2,2,3,7 for entries 0 to 7.
- R7: Under code 2 (write-one-to-clear), a bus write clears every bit written as 1. Every bit set in the w1c_set input is set on the same clock, and a set beats a clear in the same cycle.
- R8: Code 3 (read-only) and codes 4 to 7 (unknown) ignore bus writes.
- R9: Bit 2 of the PHY status value is the inverse of link_down as sampled on the previous clock edge. The other status bits are fixed at 0x7809.
- R10: Synchronous active-high reset sets every bus register to 0, sets PHY control to 0x1140, and clears the link bit.
- R11: Bus reads are combinational from bus_addr. Offsets 4 to 7 and offsets 16 and above read as 0, and a write to them changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register |
| link_down | input | 1 | High while the link is lost |
| w1c_set | input | DATA_W | Event bits ORed into every write-one-to-clear entry |

## Verification
The PHY model and the trigger bit cannot be read over the bus directly. A wrong value in either stays hidden until the next read transaction, and it then shows up in the result register one cycle after the triggering write. A stale trigger bit either makes a repeated command start a read, or stops a real rising edge from starting one. The bench therefore follows every write with a read transaction, and it compares every readable offset against its model on every clock. A corrupted general or data register is then caught in the cycle it is first addressed.

// File: rtl/mii_mgmt_regs.sv
module mii_mgmt_regs #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int NUM_GEN = 8,
  parameter int GEN_BASE = 8,
  parameter logic [3*NUM_GEN-1:0] GEN_ACC = {3'd7, 3'd3, 3'd2, 3'd2, 3'd1, 3'd1, 3'd0, 3'd0}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              link_down,
  input  logic [DATA_W-1:0] w1c_set
);

  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] MADR_A = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] MDAT_A = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] MRES_A = ADDR_W'(3);
  localparam logic [15:0] CTRL_INIT = 16'h1140;
  localparam logic [15:0] STAT_BASE = 16'h7809;
  localparam logic [15:0] CTRL_KEEP = 16'h7EFF;
  localparam int          LINK_BIT  = 2;

  logic [DATA_W-1:0] cmd_q, addr_q;
  logic [15:0]       data_q, rd_stat, phy_ctrl, phy_stat, phy_rd_val;
  logic              link_q;
  logic [DATA_W-1:0] gen_rd [NUM_GEN];
  logic [NUM_GEN-1:0] gen_wr;

  wire [4:0] phy_reg = addr_q[4:0];
  wire wr_cmd  = bus_we && (bus_addr == CMD_A);
  wire wr_madr = bus_we && (bus_addr == MADR_A);
  wire wr_mdat = bus_we && (bus_addr == MDAT_A);
  wire rd_fire = wr_cmd && bus_wdata[0] && !cmd_q[0];

  always_comb begin
    phy_stat = STAT_BASE;
    phy_stat[LINK_BIT] = link_q;
  end

  always_comb begin
    case (phy_reg)
      5'd0:    phy_rd_val = phy_ctrl;
      5'd1:    phy_rd_val = phy_stat;
      5'd10:   phy_rd_val = 16'h1800;
      default: phy_rd_val = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      rd_stat  <= '0;
      phy_ctrl <= CTRL_INIT;
      link_q   <= 1'b0;
    end else begin
      link_q <= !link_down;
      if (wr_cmd)  cmd_q  <= bus_wdata;
      if (wr_madr) addr_q <= bus_wdata;
      if (rd_fire) rd_stat <= phy_rd_val;
      if (wr_mdat) begin
        data_q <= bus_wdata[15:0];
        if (phy_reg == 5'd0) phy_ctrl <= bus_wdata[15:0] & CTRL_KEEP;
      end
    end
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    localparam logic [2:0] ACC = GEN_ACC[3*g +: 3];
    assign gen_wr[g] = bus_we && (bus_addr == ADDR_W'(GEN_BASE + g));
    if (ACC == 3'd0 || ACC == 3'd1) begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (gen_wr[g]) q <= bus_wdata;
      end
      assign gen_rd[g] = q;
    end else if (ACC == 3'd2) begin : g_w1c
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else q <= (q & ~(gen_wr[g] ? bus_wdata : '0)) | w1c_set;
      end
      assign gen_rd[g] = q;
    end else begin : g_ro
      assign gen_rd[g] = '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      CMD_A:   bus_rdata = cmd_q;
      MADR_A:  bus_rdata = addr_q;
      MDAT_A:  bus_rdata = DATA_W'(data_q);
      MRES_A:  bus_rdata = DATA_W'(rd_stat);
      default: begin
        for (int g = 0; g < NUM_GEN; g++)
          if (bus_addr == ADDR_W'(GEN_BASE + g)) bus_rdata = gen_rd[g];
      end
    endcase
  end

endmodule

// File: rtl/mii_mgmt_regs_chk.sv
module mii_mgmt_regs_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              link_down,
  input logic [DATA_W-1:0] cmd_q,
  input logic [DATA_W-1:0] addr_q,
  input logic [15:0]       phy_ctrl,
  input logic [15:0]       rd_stat,
  input logic              link_q
);

  AST_RD_REG10: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(0) && bus_wdata[0] && !cmd_q[0] && addr_q[4:0] == 5'd10)
    |=> rd_stat == 16'h1800); // R3
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(0) && cmd_q[0]) |=> $stable(rd_stat)); // R2
  AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(2) && addr_q[4:0] == 5'd0)
    |=> (!phy_ctrl[15] && !phy_ctrl[8])); // R5
  AST_CTRL_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(2) && addr_q[4:0] != 5'd0) |=> $stable(phy_ctrl)); // R5
  AST_LINK_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> link_q == !$past(link_down)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr >= ADDR_W'(4) && bus_addr <= ADDR_W'(7)) |-> bus_rdata == '0); // R11
  AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(2)) |-> bus_rdata[DATA_W-1:16] == '0); // R4

endmodule

bind mii_mgmt_regs mii_mgmt_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .link_down(link_down), .cmd_q(cmd_q), .addr_q(addr_q),
  .phy_ctrl(phy_ctrl), .rd_stat(rd_stat), .link_q(link_q)
);

// File: tb/test_mii_mgmt_regs.sv
module test_mii_mgmt_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, bus_we = 0, link_down = 1;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, w1c_set = '0, bus_rdata;
  int n_run = 0, n_fail = 0;

  mii_mgmt_regs i_mii_mgmt_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .link_down(link_down), .w1c_set(w1c_set)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int unsigned m_cmd, m_addr, m_data, m_res, m_ctrl, m_link;
  int unsigned m_gen[8];
  int m_acc[8] = '{0, 0, 1, 1, 2, 2, 3, 7};

  function automatic int unsigned m_phy(int r);
    if (r == 0) return m_ctrl;
    if (r == 1) return 32'h7809 | (m_link << 2);
    if (r == 10) return 32'h1800;
    return 0;
  endfunction

  function automatic int unsigned m_read(int a);
    if (a == 0) return m_cmd;
    if (a == 1) return m_addr;
    if (a == 2) return m_data;
    if (a == 3) return m_res;
    if (a >= 8 && a < 16) return m_gen[a-8];
    return 0;
  endfunction

  function automatic string tag_of(int a);
    if (a == 0) return "R2";
    if (a == 1) return "R1";
    if (a == 2) return "R4";
    if (a == 3) return "R3";
    if (a >= 8 && a < 12) return "R6";
    if (a == 12 || a == 13) return "R7";
    if (a == 14 || a == 15) return "R8";
    return "R11";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cmd = 0; m_addr = 0; m_data = 0; m_res = 0; m_ctrl = 32'h1140; m_link = 0;
      foreach (m_gen[i]) m_gen[i] = 0;
    end else begin
      if (bus_we && bus_addr == 0) begin
        if (bus_wdata[0] && !m_cmd[0]) m_res = m_phy(m_addr % 32);
        m_cmd = bus_wdata;
      end
      if (bus_we && bus_addr == 1) m_addr = bus_wdata;
      if (bus_we && bus_addr == 2) begin
        m_data = bus_wdata % 65536;
        if (m_addr % 32 == 0) m_ctrl = m_data & ~32'h8100;
      end
      for (int i = 0; i < 8; i++) begin
        if (m_acc[i] == 2) begin
          if (bus_we && bus_addr == 8 + i) m_gen[i] = m_gen[i] & ~bus_wdata;
          m_gen[i] = m_gen[i] | w1c_set;
        end else if (m_acc[i] <= 1 && bus_we && bus_addr == 8 + i) m_gen[i] = bus_wdata;
      end
      m_link = link_down ? 0 : 1;
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (!rst) begin
      n_run++;
      if (bus_rdata !== m_read(bus_addr)) begin
        n_fail++;
        $display("FAIL %s per-clock offset %0d: actual %h expected %h",
                 tag_of(bus_addr), bus_addr, bus_rdata, m_read(bus_addr));
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_addr = a[4:0]; bus_we = 1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic chk(input int a, input logic [31:0] exp, input string req);
    @(negedge clk); #1;
    bus_addr = a[4:0]; bus_we = 0;
    #1;
    n_run++;
    if (bus_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s offset %0d: actual %h expected %h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic phy_read(input int r);
    wr(1, r);
    wr(0, 0);
    wr(0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    // R10 reset state
    for (int a = 0; a < 16; a++) chk(a, 0, "R10");
    // R1 phy address field has no effect; R10 control reset value
    wr(1, 32'h0000_1F00); wr(0, 1);
    chk(3, 32'h1140, "R10");
    chk(1, 32'h0000_1F00, "R1");
    // R9 link down
    wr(0, 0); wr(1, 1); wr(0, 1);
    chk(3, 32'h7809, "R9");
    link_down = 0;
    wr(0, 0); wr(0, 1);
    chk(3, 32'h780D, "R9");
    // R2 no retrigger, command stored
    wr(1, 10); wr(0, 1);
    chk(3, 32'h780D, "R2");
    wr(0, 3);
    chk(3, 32'h780D, "R2");
    chk(0, 3, "R2");
    wr(0, 0); wr(0, 1);
    chk(3, 32'h1800, "R3");
    phy_read(5);
    chk(3, 0, "R3");
    wr(3, 32'hFFFF);
    chk(3, 0, "R3");
    // R4 / R5 write transactions
    wr(1, 32'h0000_0A00); wr(2, 32'hABCD_FFFF);
    chk(2, 32'h0000_FFFF, "R4");
    phy_read(0);
    chk(3, 32'h7EFF, "R5");
    wr(1, 1); wr(2, 32'h1234);
    chk(2, 32'h1234, "R4");
    phy_read(0);
    chk(3, 32'h7EFF, "R5");
    link_down = 1;
    wr(1, 0); wr(2, 32'h8100);
    phy_read(0);
    chk(3, 0, "R5");
    phy_read(1);
    chk(3, 32'h7809, "R9");
    // R6 general read/write and write-only
    wr(8, 32'hDEAD_BEEF);
    chk(8, 32'hDEAD_BEEF, "R6");
    wr(10, 32'h55);
    chk(10, 32'h55, "R6");
    // R7 write-one-to-clear with set input
    @(negedge clk); #1 w1c_set = 32'h0F0F;
    @(posedge clk); #1 w1c_set = 0;
    chk(12, 32'h0F0F, "R7");
    wr(12, 32'h0003);
    chk(12, 32'h0F0C, "R7");
    chk(13, 32'h0F0F, "R7");
    @(negedge clk); #1 bus_addr = 13; bus_we = 1; bus_wdata = 32'h0101; w1c_set = 32'h0100;
    @(posedge clk); #1 bus_we = 0; w1c_set = 0;
    chk(13, 32'h0F0E, "R7");
    // R8 read-only and unknown codes
    wr(14, 32'hFFFF_FFFF);
    chk(14, 0, "R8");
    wr(15, 32'h1234_5678);
    chk(15, 0, "R8");
    // R11 unmapped offsets
    wr(5, 32'h1234);
    chk(5, 0, "R11");
    wr(20, 32'hFFFF_FFFF);
    chk(20, 0, "R11");
    chk(8, 32'hDEAD_BEEF, "R11");
    // R10 reset mid-run
    @(negedge clk); #1 rst = 1;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    chk(8, 0, "R10");
    chk(12, 0, "R10");
    phy_read(0);
    chk(3, 32'h1140, "R10");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule